// File: doc/BRIEF.md
# Branch Target Prediction Cache

This block sits next to the instruction fetch path and steers the next fetch address. Every cycle the fetch stage offers its current fetch address. The block looks that address up in a direct-mapped table in the same cycle as the instruction cache lookup. The table holds, for each slot, a tag, a branch target and a 2-bit saturating history counter. When a valid entry matches and its counter leans taken, the registered next fetch address becomes the stored target. In every other case fetch continues sequentially, two bytes on, because instructions are 16-bit aligned.

The execute stage reports each resolved branch on a resolve port: its address, whether it was taken, and its real target. The block looks that branch up again through a second read port. This gives the prediction that fetch received. The block then flags a misprediction when the direction or the taken target differs. The same port trains the table. A hit moves the counter one step and refreshes the target when taken. A taken branch that missed claims its slot in the weakly-taken state. A not-taken branch that missed leaves the table alone.

On a misprediction the block raises a one-cycle flush/redirect pulse and loads the correct address. It then holds its pipeline-valid output low for a fixed refill penalty while the fetch and execute stages refill.

Top module: `btc_top`

## Requirements
- R1: After synchronous reset every entry is invalid, next_pc_o is 0, pred_taken_o and redirect_o are 0 and pipe_valid_o is 1; any lookup then predicts sequentially.
- R2: A fetch address presented with fetch_valid_i in one cycle sets next_pc_o and pred_taken_o at the next rising clock edge.
- R3: A lookup that hits a valid entry whose counter is 2 or 3 gives pred_taken_o=1 and next_pc_o equal to the stored target.
- R4: A lookup that misses, or hits an entry whose counter is 0 or 1, gives pred_taken_o=0 and next_pc_o equal to the fetch address plus 2.
- R5: In a cycle with fetch_valid_i low and no misprediction, next_pc_o keeps its value and pred_taken_o goes to 0.
- R6: A resolved branch is mispredicted when its direction differs from the table's prediction, or when it is taken and its target differs from the stored one. A misprediction makes redirect_o 1 for one cycle, with next_pc_o equal to the target when taken or the branch address plus 2 when not taken. This overrides any fetch lookup that cycle.
- R7: After the edge that raises redirect_o, pipe_valid_o is 0 for exactly PENALTY (default 7) cycles and then returns to 1; a new misprediction restarts the count.
- R8: A taken branch that misses is written into its slot with its target and counter value 2 (weakly taken), so the next lookup of that address predicts taken.
- R9: A not-taken branch that misses allocates nothing and raises no redirect; an existing entry in its slot survives.
- R10: On a hit the counter increments toward 3 on taken and decrements toward 0 on not taken, saturating at both ends; a taken hit also stores the reported target.
- R11: The table is direct-mapped, indexed by address bits [log2(ENTRIES):1] and tagged by all bits above; an address with the same index and a different tag misses, and allocating it evicts the older entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid_i | input | 1 | Fetch address valid this cycle |
| fetch_pc_i | input | AW | Current fetch address |
| resolve_valid_i | input | 1 | A branch resolves this cycle |
| resolve_pc_i | input | AW | Address of the resolved branch |
| resolve_taken_i | input | 1 | Actual direction of the resolved branch |
| resolve_target_i | input | AW | Actual target of the resolved branch |
| next_pc_o | output | AW | Next fetch address (predicted or corrected) |
| pred_taken_o | output | 1 | Next fetch address came from a taken prediction |
| redirect_o | output | 1 | One-cycle flush and redirect after a misprediction |
| pipe_valid_o | output | 1 | Low while the pipeline refills after a misprediction |

## Verification
The bench builds the block with AW=12, ENTRIES=8 and PENALTY=7. This gives every slot an index of three bits and a tag of eight bits. That small table lets the bench fill and revisit every slot. It can force evictions between two tags in one slot, and walk a counter through all four values against both saturation limits. A pseudo-random phase of mixed fetch and resolve traffic over the same two tags follows, including resolves that fall during a refill. A reference table kept in the bench predicts every output of every cycle.

// File: rtl/btc_pkg.sv
package btc_pkg;

  typedef logic [1:0] hist_t;

  localparam hist_t HIST_WEAK_TAKEN = 2'd2;
  localparam hist_t HIST_MAX        = 2'd3;
  localparam hist_t HIST_MIN        = 2'd0;

  // Saturating two-bit history step.
  function automatic hist_t hist_step(input hist_t cur, input logic taken);
    if (taken) return (cur == HIST_MAX) ? cur : cur + 2'd1;
    else       return (cur == HIST_MIN) ? cur : cur - 2'd1;
  endfunction

  function automatic logic hist_predicts_taken(input hist_t cur);
    return cur[1];
  endfunction

endpackage

// File: rtl/btc_split.sv
module btc_split #(
  parameter int AW    = 32,
  parameter int IDX_W = 8,
  localparam int TAG_W = AW - IDX_W - 1
) (
  input  logic [AW-1:0]    pc_i,
  output logic [IDX_W-1:0] idx_o,
  output logic [TAG_W-1:0] tag_o
);
  // Bit 0 is always zero for 16-bit aligned instructions.
  logic unused_lsb;
  assign unused_lsb = pc_i[0];
  assign idx_o = pc_i[IDX_W:1];
  assign tag_o = pc_i[AW-1:IDX_W+1];
endmodule

// File: rtl/btc_store.sv
module btc_store
  import btc_pkg::*;
#(
  parameter int AW      = 32,
  parameter int ENTRIES = 256,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int TAG_W  = AW - IDX_W - 1,
  localparam int NRD    = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NRD-1:0][IDX_W-1:0] rd_idx_i,
  input  logic [NRD-1:0][TAG_W-1:0] rd_tag_i,
  output logic [NRD-1:0]            rd_hit_o,
  output hist_t [NRD-1:0]           rd_hist_o,
  output logic [NRD-1:0][AW-1:0]    rd_tgt_o,
  input  logic                      we_i,
  input  logic [IDX_W-1:0]          w_idx_i,
  input  logic [TAG_W-1:0]          w_tag_i,
  input  logic [AW-1:0]             w_tgt_i,
  input  hist_t                     w_hist_i
);
  logic [TAG_W-1:0] tag_mem  [ENTRIES];
  logic [AW-1:0]    tgt_mem  [ENTRIES];
  hist_t            hist_mem [ENTRIES];
  logic [ENTRIES-1:0] vld;

  // Memory arrays: write-only sequential process, no reset.
  always_ff @(posedge clk) begin
    if (we_i) begin
      tag_mem[w_idx_i]  <= w_tag_i;
      tgt_mem[w_idx_i]  <= w_tgt_i;
      hist_mem[w_idx_i] <= w_hist_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) vld <= '0;
    else if (we_i) vld[w_idx_i] <= 1'b1;
  end

  // Asynchronous read ports; contents before this cycle's write.
  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rd_hit_o[p]  = vld[rd_idx_i[p]] && (tag_mem[rd_idx_i[p]] == rd_tag_i[p]);
    assign rd_hist_o[p] = hist_mem[rd_idx_i[p]];
    assign rd_tgt_o[p]  = tgt_mem[rd_idx_i[p]];
  end

  assert_write_sets_valid_R8: assert property (@(posedge clk) disable iff (rst)
    (!rst && we_i) |=> vld[$past(w_idx_i)]);

  assert_write_hits_next_R11: assert property (@(posedge clk) disable iff (rst)
    (!rst && we_i && rd_idx_i[1] == w_idx_i) |=>
      ((rd_idx_i[1] != $past(w_idx_i)) || (rd_tag_i[1] != $past(w_tag_i)) || rd_hit_o[1]));
endmodule

// File: rtl/btc_refill.sv
module btc_refill #(
  parameter int PENALTY = 7,
  localparam int CW = $clog2(PENALTY + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic load_i,
  output logic valid_o
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load_i)      cnt <= CW'(PENALTY);
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign valid_o = (cnt == '0);

  assert_refill_restart_R7: assert property (@(posedge clk) disable iff (rst)
    (!rst && load_i) |=> (cnt == CW'(PENALTY)));

  assert_refill_countdown_R7: assert property (@(posedge clk) disable iff (rst)
    (!rst && !load_i && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/btc_top.sv
module btc_top
  import btc_pkg::*;
#(
  parameter int AW          = 32,
  parameter int ENTRIES     = 256,
  parameter int PENALTY     = 7,
  parameter int INSTR_BYTES = 2,
  localparam int IDX_W = $clog2(ENTRIES),
  localparam int TAG_W = AW - IDX_W - 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fetch_valid_i,
  input  logic [AW-1:0] fetch_pc_i,
  input  logic          resolve_valid_i,
  input  logic [AW-1:0] resolve_pc_i,
  input  logic          resolve_taken_i,
  input  logic [AW-1:0] resolve_target_i,
  output logic [AW-1:0] next_pc_o,
  output logic          pred_taken_o,
  output logic          redirect_o,
  output logic          pipe_valid_o
);
  localparam int FETCH_PORT = 0;
  localparam int RES_PORT   = 1;

  logic [1:0][IDX_W-1:0] rd_idx;
  logic [1:0][TAG_W-1:0] rd_tag;
  logic [1:0]            rd_hit;
  hist_t [1:0]           rd_hist;
  logic [1:0][AW-1:0]    rd_tgt;

  logic [1:0][AW-1:0]    port_pc;
  assign port_pc[FETCH_PORT] = fetch_pc_i;
  assign port_pc[RES_PORT]   = resolve_pc_i;

  for (genvar p = 0; p < 2; p++) begin : g_split
    btc_split #(.AW(AW), .IDX_W(IDX_W)) u_split (
      .pc_i (port_pc[p]),
      .idx_o(rd_idx[p]),
      .tag_o(rd_tag[p])
    );
  end

  logic          we;
  logic [AW-1:0] w_tgt;
  hist_t         w_hist;

  btc_store #(.AW(AW), .ENTRIES(ENTRIES)) u_store (
    .clk      (clk),
    .rst      (rst),
    .rd_idx_i (rd_idx),
    .rd_tag_i (rd_tag),
    .rd_hit_o (rd_hit),
    .rd_hist_o(rd_hist),
    .rd_tgt_o (rd_tgt),
    .we_i     (we),
    .w_idx_i  (rd_idx[RES_PORT]),
    .w_tag_i  (rd_tag[RES_PORT]),
    .w_tgt_i  (w_tgt),
    .w_hist_i (w_hist)
  );

  // Fetch-side prediction.
  logic          fetch_pred;
  logic [AW-1:0] fetch_next;
  always_comb begin
    fetch_pred = rd_hit[FETCH_PORT] && hist_predicts_taken(rd_hist[FETCH_PORT]);
    fetch_next = fetch_pred ? rd_tgt[FETCH_PORT] : fetch_pc_i + AW'(INSTR_BYTES);
  end

  // Resolve-side check and training.
  logic          res_pred;
  logic          mispredict;
  logic [AW-1:0] correct_pc;
  always_comb begin
    res_pred   = rd_hit[RES_PORT] && hist_predicts_taken(rd_hist[RES_PORT]);
    mispredict = resolve_valid_i &&
                 ((resolve_taken_i != res_pred) ||
                  (resolve_taken_i && (rd_tgt[RES_PORT] != resolve_target_i)));
    correct_pc = resolve_taken_i ? resolve_target_i : resolve_pc_i + AW'(INSTR_BYTES);
    we         = resolve_valid_i && (rd_hit[RES_PORT] || resolve_taken_i);
    w_hist     = rd_hit[RES_PORT] ? hist_step(rd_hist[RES_PORT], resolve_taken_i)
                                  : HIST_WEAK_TAKEN;
    w_tgt      = (rd_hit[RES_PORT] && !resolve_taken_i) ? rd_tgt[RES_PORT] : resolve_target_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      next_pc_o    <= '0;
      pred_taken_o <= 1'b0;
      redirect_o   <= 1'b0;
    end else if (mispredict) begin
      next_pc_o    <= correct_pc;
      pred_taken_o <= 1'b0;
      redirect_o   <= 1'b1;
    end else begin
      redirect_o   <= 1'b0;
      pred_taken_o <= fetch_valid_i && fetch_pred;
      if (fetch_valid_i) next_pc_o <= fetch_next;
    end
  end

  btc_refill #(.PENALTY(PENALTY)) u_refill (
    .clk    (clk),
    .rst    (rst),
    .load_i (mispredict),
    .valid_o(pipe_valid_o)
  );

  assert_flush_blocks_valid_R7: assert property (@(posedge clk) disable iff (rst)
    redirect_o |-> !pipe_valid_o);

  assert_redirect_not_predicted_R6: assert property (@(posedge clk) disable iff (rst)
    redirect_o |-> !pred_taken_o);

  assert_idle_holds_pc_R5: assert property (@(posedge clk) disable iff (rst)
    (!rst && !fetch_valid_i && !mispredict) |=>
      ($stable(next_pc_o) && !pred_taken_o && !redirect_o));

  assert_redirect_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    (!rst && !mispredict) |=> !redirect_o);
endmodule

// File: tb/btc_top_test.sv
module btc_top_test;
  localparam int AW = 12;
  localparam int ENTRIES = 8;
  localparam int PEN = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fv = 1'b0, rv = 1'b0, rt = 1'b0;
  logic [AW-1:0] fpc = '0, rpc = '0, rtgt = '0;
  logic [AW-1:0] next_pc;
  logic pred_taken, redirect, pipe_valid;

  always #4 clk = ~clk;

  btc_top #(.AW(AW), .ENTRIES(ENTRIES), .PENALTY(PEN)) uut (
    .clk(clk), .rst(rst),
    .fetch_valid_i(fv), .fetch_pc_i(fpc),
    .resolve_valid_i(rv), .resolve_pc_i(rpc),
    .resolve_taken_i(rt), .resolve_target_i(rtgt),
    .next_pc_o(next_pc), .pred_taken_o(pred_taken),
    .redirect_o(redirect), .pipe_valid_o(pipe_valid)
  );

  int total = 0;
  int bad = 0;

  // Reference table built from the requirements.
  logic          m_vld [ENTRIES];
  logic [7:0]    m_tag [ENTRIES];
  logic [AW-1:0] m_tgt [ENTRIES];
  logic [1:0]    m_ctr [ENTRIES];
  logic [AW-1:0] e_pc = '0;
  int            e_cnt = 0;

  task automatic check(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic m_hit(input logic [AW-1:0] pc);
    return m_vld[pc[3:1]] && (m_tag[pc[3:1]] == pc[11:4]);
  endfunction

  // One cycle: drive at negedge, compute expectations, check at next negedge.
  task automatic cyc(input logic f_v, input logic [AW-1:0] f_pc,
                     input logic r_v, input logic [AW-1:0] r_pc,
                     input logic r_t, input logic [AW-1:0] r_tg, input string tag);
    logic fh, fp, rh, rp, mis;
    logic [AW-1:0] e_next;
    logic e_pred;
    int i;
    fv = f_v; fpc = f_pc; rv = r_v; rpc = r_pc; rt = r_t; rtgt = r_tg;
    fh = m_hit(f_pc);
    fp = fh && m_ctr[f_pc[3:1]][1];
    rh = m_hit(r_pc);
    rp = rh && m_ctr[r_pc[3:1]][1];
    i  = int'(r_pc[3:1]);
    mis = r_v && ((r_t != rp) || (r_t && m_tgt[i] != r_tg));
    if (mis) begin
      e_next = r_t ? r_tg : r_pc + 12'd2;
      e_pred = 1'b0;
    end else begin
      e_pred = f_v && fp;
      e_next = f_v ? (fp ? m_tgt[f_pc[3:1]] : f_pc + 12'd2) : e_pc;
    end
    if (r_v && rh) begin
      if (r_t) begin
        m_ctr[i] = (m_ctr[i] == 2'd3) ? 2'd3 : m_ctr[i] + 2'd1;
        m_tgt[i] = r_tg;
      end else begin
        m_ctr[i] = (m_ctr[i] == 2'd0) ? 2'd0 : m_ctr[i] - 2'd1;
      end
    end else if (r_v && r_t) begin
      m_vld[i] = 1'b1; m_tag[i] = r_pc[11:4]; m_tgt[i] = r_tg; m_ctr[i] = 2'd2;
    end
    if (mis) e_cnt = PEN;
    else if (e_cnt > 0) e_cnt--;
    e_pc = e_next;
    @(negedge clk);
    check(tag, "next_pc", int'(next_pc), int'(e_next));
    check(tag, "pred_taken", int'(pred_taken), int'(e_pred));
    check(tag, "redirect", int'(redirect), int'(mis));
    check(tag, "pipe_valid", int'(pipe_valid), int'(e_cnt == 0));
  endtask

  task automatic look(input logic [AW-1:0] pc, input string tag);
    cyc(1'b1, pc, 1'b0, '0, 1'b0, '0, tag);
  endtask

  task automatic res(input logic [AW-1:0] pc, input logic t, input logic [AW-1:0] tg,
                     input string tag);
    cyc(1'b0, '0, 1'b1, pc, t, tg, tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int k = 0; k < n; k++) cyc(1'b0, '0, 1'b0, '0, 1'b0, '0, tag);
  endtask

  function automatic logic [AW-1:0] mk(input logic [7:0] t, input int idx);
    return {t, 3'(idx), 1'b0};
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : stim
    logic [15:0] lf;
    for (int k = 0; k < ENTRIES; k++) begin
      m_vld[k] = 1'b0; m_tag[k] = '0; m_tgt[k] = '0; m_ctr[k] = '0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state.
    check("R1", "next_pc", int'(next_pc), 0);
    check("R1", "pred_taken", int'(pred_taken), 0);
    check("R1", "redirect", int'(redirect), 0);
    check("R1", "pipe_valid", int'(pipe_valid), 1);
    for (int k = 0; k < ENTRIES; k++) look(mk(8'h5A, k), "R1_R4_empty");

    // R8, R6, R7, R3: allocate every slot, refill, then predict.
    for (int k = 0; k < ENTRIES; k++) begin
      res(mk(8'h5A, k), 1'b1, 12'h800 + 12'(k * 16), "R8_R6_alloc");
      idle(PEN + 1, "R7_refill");
      look(mk(8'h5A, k), "R3_R2_hit");
    end

    // R5: idle fetch holds the address.
    look(mk(8'h5A, 1), "R3");
    idle(3, "R5_hold");

    // R9: not-taken miss allocates nothing, old entry survives.
    res(mk(8'h33, 2), 1'b0, 12'h0F0, "R9_nt_miss");
    look(mk(8'h33, 2), "R9_still_miss");
    look(mk(8'h5A, 2), "R9_survivor");

    // R11: same index, other tag, evicts.
    look(mk(8'h33, 3), "R11_tag_miss");
    res(mk(8'h33, 3), 1'b1, 12'h7A0, "R11_evict");
    idle(PEN, "R7");
    look(mk(8'h33, 3), "R11_new");
    look(mk(8'h5A, 3), "R11_old_gone");

    // R10: counter walk on slot 4 (starts at 2).
    res(mk(8'h5A, 4), 1'b1, 12'h840, "R10_inc3");
    res(mk(8'h5A, 4), 1'b1, 12'h840, "R10_sat3");
    res(mk(8'h5A, 4), 1'b0, 12'h840, "R10_dec2_R6");
    idle(PEN, "R7");
    look(mk(8'h5A, 4), "R10_R3_ctr2");
    res(mk(8'h5A, 4), 1'b0, 12'h840, "R10_dec1_R6");
    idle(PEN, "R7");
    look(mk(8'h5A, 4), "R10_R4_ctr1");
    res(mk(8'h5A, 4), 1'b0, 12'h840, "R10_dec0");
    res(mk(8'h5A, 4), 1'b0, 12'h840, "R10_sat0");
    res(mk(8'h5A, 4), 1'b1, 12'h840, "R10_inc1_R6");
    idle(PEN, "R7");
    look(mk(8'h5A, 4), "R10_R4_ctr1b");
    res(mk(8'h5A, 4), 1'b1, 12'h840, "R10_inc2_R6");
    idle(PEN, "R7");
    look(mk(8'h5A, 4), "R10_R3_ctr2b");
    // R10/R6: taken with a new target replaces it.
    res(mk(8'h5A, 5), 1'b1, 12'h9C6, "R10_R6_newtgt");
    look(mk(8'h5A, 5), "R6_during_refill");
    idle(PEN, "R7");
    look(mk(8'h5A, 5), "R10_R3_newtgt");
    // R6 overrides a simultaneous fetch lookup; R7 restart mid-refill.
    cyc(1'b1, mk(8'h5A, 6), 1'b1, mk(8'h5A, 7), 1'b0, '0, "R6_override");
    idle(3, "R7");
    res(mk(8'h5A, 6), 1'b0, '0, "R7_restart");
    idle(PEN + 1, "R7");

    // Pseudo-random mixed traffic over two tags.
    lf = 16'hACE1;
    for (int k = 0; k < 600; k++) begin
      cyc(lf[0], {lf[1] ? 8'h5A : 8'h33, lf[4:2], 1'b0},
          lf[5] & lf[14], {lf[6] ? 8'h5A : 8'h33, lf[9:7], 1'b0},
          lf[10], {4'h8, lf[13:11], 5'b0}, "R2_R3_R4_R10_R11_mix");
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    end
    idle(PEN + 1, "R7");

    // R1: reset again empties the table.
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < ENTRIES; k++) m_vld[k] = 1'b0;
    e_pc = '0; e_cnt = 0;
    check("R1", "pipe_valid", int'(pipe_valid), 1);
    check("R1", "next_pc", int'(next_pc), 0);
    for (int k = 0; k < ENTRIES; k++) look(mk(8'h5A, k), "R1_cleared");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule